// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Responder

This block is the interrupt side of a bus peripheral. It raises a request line when the peripheral's completion flag is set and its interrupt enable is on. It then takes part in a priority chain in which the processor's acknowledge passes from device to device. A device with a pending request keeps the acknowledge from travelling further. It places its vector on the data lines and replies. A device with nothing pending passes the acknowledge on to its downstream neighbour.

The completion flag comes from the peripheral's register file. It may be set by a finished transfer count, by an attention input from the attached equipment, or by a bus timeout. A rising edge of the flag arms one interrupt. Once that interrupt has been serviced, the request stays low until the flag falls and rises again.

When the acknowledge first arrives, the responder decides whether to block it or pass it. That decision holds until the acknowledge is withdrawn, so a request that appears in the middle of a chain cycle cannot cut into the signal already travelling downstream. The vector is set by a 7-bit selector that supplies bits 8:2. Bits 1:0 are always zero, and a selector value of 21 gives vector 124 octal.

Top module: `irq_chain_responder`

## Requirements
- R1: While reset (rst_n low) is applied and in the first cycle after it, irq, iak_out, reply and vec_oe are 0 and vec_data is 0.
- R2: irq is 1 exactly when int_en is 1, ready is 1 and an interrupt is armed. A rising edge of ready arms an interrupt, and irq shows it one clock later.
- R3: After an interrupt is serviced, irq stays 0 even with ready and int_en held at 1. irq returns one clock after ready goes 0 and then 1 again.
- R4: Clearing int_en while an interrupt is armed drops irq at once. Setting int_en again brings irq back without a new edge on ready.
- R5: If iak_in and din_strobe are both 1 at a clock edge while irq is 1, then after that edge reply is 1, vec_oe is 1, irq is 0 and iak_out is 0.
- R6: If iak_in is 1 at a clock edge while irq is 0, then iak_out is 1 after that edge and reply and vec_oe stay 0. iak_out returns to 0 one clock after iak_in falls.
- R7: The pass or block decision made when iak_in arrives holds until iak_in is 0. A request that appears during a pass does not drop iak_out or raise reply.
- R8: reply, vec_oe and vec_data stay asserted while din_strobe or iak_in is 1. They drop one clock after both are 0.
- R9: While vec_oe is 1, vec_data equals vec_sel multiplied by 4, with bits 1:0 zero and all bits above 8 zero. While vec_oe is 0, vec_data is 0.
- R10: If iak_in arrives with irq 1 but din_strobe 0, the acknowledge is blocked (iak_out 0) and the reply waits for din_strobe. If iak_in is withdrawn before din_strobe comes, the request stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_en | input | 1 | Interrupt enable from the register file |
| ready | input | 1 | Completion flag from the register file |
| din_strobe | input | 1 | Processor data-in strobe |
| iak_in | input | 1 | Acknowledge arriving from upstream in the chain |
| vec_sel | input | SEL_W (7) | Selector for vector bits 8:2 |
| irq | output | 1 | Interrupt request |
| iak_out | output | 1 | Acknowledge forwarded downstream |
| reply | output | 1 | Reply to the processor |
| vec_oe | output | 1 | Vector drive enable for the data lines |
| vec_data | output | DATA_W (16) | Vector value, zero when not driving |

## Verification
Acknowledges are tried in three orders, and each tells a different pair of behaviours apart. An acknowledge together with the strobe while a request is pending separates serving from passing. An acknowledge ahead of the strobe separates blocking-and-waiting from serving at once, and also an abandoned acknowledge from one that was serviced. An acknowledge arriving while nothing is pending, with the enable turned on partway through, shows whether the forwarding decision is held. The selector is swept over all 128 values, each through a full serve, so that any dropped, shifted or leaked vector bit is caught. Edges of ready and int_en are toggled around each service to tell one-shot arming apart from level-triggered requests.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_SERVE = 2'd2,
    ST_PASS  = 2'd3
  } ack_state_e;

  function automatic logic request_live(input logic armed, input logic en, input logic flag);
    return armed & en & flag;
  endfunction

endpackage

// File: rtl/irq_arm.sv
module irq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic int_en,
  input  logic ready,
  input  logic service,
  output logic ready_rise_o,
  output logic armed_o,
  output logic irq_o
);
  import irq_resp_pkg::*;

  logic ready_q;

  assign ready_rise_o = ready & ~ready_q;
  assign irq_o        = request_live(armed_o, int_en, ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      ready_q <= ready;
      if (ready_rise_o)
        armed_o <= 1'b1;
      else if (service)
        armed_o <= 1'b0;
    end
  end

  // R3: a serviced request stays disarmed unless a fresh edge arrived
  a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    service && !ready_rise_o |=> !armed_o);

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic din_strobe,
  input  logic iak_in,
  output logic service_o,
  output logic serve_o,
  output logic pass_o
);
  import irq_resp_pkg::*;

  ack_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    service_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (iak_in) begin
          if (!pending) begin
            state_d = ST_PASS;
          end else if (din_strobe) begin
            state_d   = ST_SERVE;
            service_o = 1'b1;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (!iak_in) begin
          state_d = ST_IDLE;
        end else if (din_strobe) begin
          state_d   = ST_SERVE;
          service_o = 1'b1;
        end
      end
      ST_SERVE: begin
        if (!din_strobe && !iak_in) state_d = ST_IDLE;
      end
      ST_PASS: begin
        if (!iak_in) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign serve_o = (state_q == ST_SERVE);
  assign pass_o  = (state_q == ST_PASS);

  // R5: a reply only starts after strobe and acknowledge were both seen
  a_r5_reply_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serve_o) |-> $past(din_strobe && iak_in));

  // R8: the reply is held while either processor signal is still up
  a_r8_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
    serve_o && (din_strobe || iak_in) |=> serve_o);

  // R6: forwarding only follows an acknowledge present on the previous edge
  a_r6_pass_source: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> $past(iak_in));

  // R7: once passing, no reply can begin until the acknowledge is gone
  a_r7_pass_held: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o && iak_in |=> pass_o && !serve_o);

endmodule

// File: rtl/irq_vec_drive.sv
module irq_vec_drive #(
  parameter int DATA_W  = 16,
  parameter int SEL_W   = 7,
  parameter int SEL_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] data_o
);
  localparam int VEC_W = SEL_W + SEL_LSB;

  function automatic logic [DATA_W-1:0] vec_word(input logic [SEL_W-1:0] s);
    logic [VEC_W-1:0] v;
    v = {s, {SEL_LSB{1'b0}}};
    return DATA_W'(v);
  endfunction

  assign data_o = oe ? vec_word(sel) : '0;

  // R9: no stray vector bits on the data lines when not driving
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> data_o == '0);

endmodule

// File: rtl/irq_chain_responder.sv
module irq_chain_responder #(
  parameter int DATA_W  = 16,
  parameter int SEL_W   = 7,
  parameter int SEL_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_en,
  input  logic              ready,
  input  logic              din_strobe,
  input  logic              iak_in,
  input  logic [SEL_W-1:0]  vec_sel,
  output logic              irq,
  output logic              iak_out,
  output logic              reply,
  output logic              vec_oe,
  output logic [DATA_W-1:0] vec_data
);
  localparam int VEC_W = SEL_W + SEL_LSB;

  logic service_w;
  logic serve_w;
  logic pass_w;
  logic ready_rise_w;
  logic armed_w;

  irq_arm u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_en      (int_en),
    .ready       (ready),
    .service     (service_w),
    .ready_rise_o(ready_rise_w),
    .armed_o     (armed_w),
    .irq_o       (irq)
  );

  irq_ack_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending   (irq),
    .din_strobe(din_strobe),
    .iak_in    (iak_in),
    .service_o (service_w),
    .serve_o   (serve_w),
    .pass_o    (pass_w)
  );

  irq_vec_drive #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .SEL_LSB(SEL_LSB)
  ) u_vec (
    .clk   (clk),
    .rst_n (rst_n),
    .oe    (serve_w),
    .sel   (vec_sel),
    .data_o(vec_data)
  );

  assign reply   = serve_w;
  assign vec_oe  = serve_w;
  assign iak_out = pass_w;

  // R5: a request is withdrawn the moment it is answered
  a_r5_reply_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reply) |-> !irq);

  // R6: forwarding and replying never overlap
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iak_out, reply}));

  // R9: driven vector is the selector scaled by four
  a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> vec_data == (DATA_W'(vec_sel) * (DATA_W'(1) << SEL_LSB)));

  // R2: request never shown without enable and flag
  a_r2_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> int_en && ready && (armed_w || $past(ready_rise_w)));

  initial begin
    a_w_fit: assert (VEC_W <= DATA_W);
  end

endmodule

// File: tb/sim_irq_chain_responder.sv
module sim_irq_chain_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_en = 1'b0;
  logic        ready = 1'b0;
  logic        din_strobe = 1'b0;
  logic        iak_in = 1'b0;
  logic [6:0]  vec_sel = 7'd21;
  logic        irq, iak_out, reply, vec_oe;
  logic [15:0] vec_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  irq_chain_responder u0 (
    .clk(clk), .rst_n(rst_n), .int_en(int_en), .ready(ready),
    .din_strobe(din_strobe), .iak_in(iak_in), .vec_sel(vec_sel),
    .irq(irq), .iak_out(iak_out), .reply(reply), .vec_oe(vec_oe),
    .vec_data(vec_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // outputs packed as {irq, iak_out, reply, vec_oe}
  function automatic logic [3:0] flags();
    return {irq, iak_out, reply, vec_oe};
  endfunction

  task automatic arm();
    ready = 1'b0; tick();
    ready = 1'b1; tick();
  endtask

  task automatic serve(input string tag, input logic [15:0] expv);
    din_strobe = 1'b1; iak_in = 1'b1; tick();
    chk({tag, " R5 flags"}, flags(), 4'b0011);
    chk({tag, " R9 vector"}, vec_data, expv);
    din_strobe = 1'b0; tick();
    chk({tag, " R8 hold"}, flags(), 4'b0011);
    iak_in = 1'b0; tick();
    chk({tag, " R8 release"}, flags(), 4'b0000);
    chk({tag, " R9 quiet"}, vec_data, 16'h0);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 in reset", {flags(), vec_data}, 20'h0);
    rst_n = 1'b1; tick();
    chk("R1 after reset", {flags(), vec_data}, 20'h0);

    // R2: arming and gating
    int_en = 1'b1; ready = 1'b1;
    #1; chk("R2 not yet", irq, 1'b0);
    tick();
    chk("R2 raised", irq, 1'b1);

    // R4: mask and unmask
    int_en = 1'b0; #1;
    chk("R4 masked", irq, 1'b0);
    int_en = 1'b1; #1;
    chk("R4 restored", irq, 1'b1);

    // R5/R8/R9: serve with default selector (124 octal)
    serve("default", 16'o124);

    // R3: one-shot
    tick();
    chk("R3 stays low", irq, 1'b0);
    arm();
    chk("R3 rearmed", irq, 1'b1);

    // R10: acknowledge before strobe, then abandoned
    iak_in = 1'b1; tick();
    chk("R10 blocked", flags(), 4'b1000);
    iak_in = 1'b0; tick();
    chk("R10 still pending", flags(), 4'b1000);
    // R10: acknowledge then strobe later
    iak_in = 1'b1; tick();
    chk("R10 hold", flags(), 4'b1000);
    din_strobe = 1'b1; tick();
    chk("R10 served", flags(), 4'b0011);
    din_strobe = 1'b0; iak_in = 1'b0; tick();
    chk("R10 done", flags(), 4'b0000);

    // R6/R7: pass with nothing pending, enable rising mid-pass
    int_en = 1'b0; arm();
    iak_in = 1'b1; din_strobe = 1'b1; tick();
    chk("R6 pass", flags(), 4'b0100);
    int_en = 1'b1; tick();
    chk("R7 held", flags(), 4'b1100);
    din_strobe = 1'b0; tick();
    chk("R7 still passing", flags(), 4'b1100);
    iak_in = 1'b0; #1;
    chk("R6 lag", iak_out, 1'b1);
    tick();
    chk("R6 released", flags(), 4'b1000);
    chk("R6 data quiet", vec_data, 16'h0);
    serve("after pass", 16'o124);

    // R9: full selector sweep
    for (int s = 0; s < 128; s++) begin
      vec_sel = 7'(s);
      arm();
      chk("R2 sweep armed", irq, 1'b1);
      serve("sweep", 16'(s * 4));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule